// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records the moment an external signal changes. A free-running counter value comes in on an input bus. When the chosen edge appears on the capture pin, the block copies that counter value into its capture register. It also sets a sticky capture flag and raises an interrupt request if interrupts are enabled. The pin first passes through a synchroniser. An optional agreement filter follows, which rejects pulses shorter than a fixed number of clock samples.

Software clears the flag with a write-one-to-clear strobe and can load the capture register directly. A mode input tells the block that the capture register is currently the counter's upper limit. While it is set, the pin is ignored entirely. The counter, the waveform logic and the register decode sit outside the block.

Top module: `capture_stamp`

## Requirements
- R1: After reset, `cap_reg` is 0, `cap_flag` is 0 and `cap_irq` is 0.
- R2: With the filter off, a pin level change that is sampled at clock edge e0 causes a capture at edge e2. The flag is therefore visible two edges after the sample, because of the two-stage synchroniser.
- R3: With the filter on, the filtered level takes a new value only after four consecutive clock samples of the synchronised pin agree on it. A pulse lasting three or fewer samples causes no capture.
- R4: Turning the filter on delays a capture by exactly four clock cycles compared with the unfiltered path.
- R5: `edge_sel` = 0 selects falling edges (1 to 0) and `edge_sel` = 1 selects rising edges (0 to 1). The other direction never captures.
- R6: On a capture, `cap_reg` takes the `cnt_val` value present at the capturing edge, and `cap_flag` becomes 1.
- R7: `cap_irq` is 1 exactly when `cap_flag` is 1 and `irq_en` is 1.
- R8: While `top_is_cap` is 1, no capture happens. `cap_reg` and `cap_flag` then change only through the software strobes.
- R9: A one-cycle `flag_clr` pulse clears `cap_flag`. If a capture happens in the same cycle, the flag stays set.
- R10: Changing `edge_sel` while the filtered level is steady causes no capture. Only a change between consecutive level samples counts as an edge.
- R11: A `cap_wr` pulse loads `cap_wdata` into `cap_reg`. If a capture happens in the same cycle, the captured counter value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| cnt_val | input | CNT_W | Free-running counter value |
| filt_en | input | 1 | Enable for the four-sample agreement filter |
| edge_sel | input | 1 | Trigger edge: 0 falling, 1 rising |
| irq_en | input | 1 | Capture interrupt enable |
| top_is_cap | input | 1 | Capture register serves as counter limit; capture disabled |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cap_wr | input | 1 | Software load strobe for the capture register |
| cap_wdata | input | CNT_W | Software load data |
| cap_reg | output | CNT_W | Capture register |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter, two synchroniser stages and a four-sample filter. With these values every random counter value is a full 16-bit word. Pin runs of one to eight cycles fall on both sides of the filter threshold, so rejected and accepted pulses both occur. Because the filter is short, a cycle-by-cycle reference model stays small, and the exact-latency checks for the unfiltered and filtered paths can be written as fixed edge counts.

// File: rtl/capture_stamp_pkg.sv
package capture_stamp_pkg;

    localparam int DEF_CNT_W       = 16;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_FILT_LEN    = 4;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic evt;
        logic wr;
        logic clr;
    } cap_ctl_t;

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prv);
        if (sel == EDGE_RISE) begin
            return cur & ~prv;
        end
        return ~cur & prv;
    endfunction

endpackage

// File: rtl/capture_stamp_sync.sv
module capture_stamp_sync #(
    parameter int STAGES = capture_stamp_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/capture_stamp_filter.sv
module capture_stamp_filter #(
    parameter int LEN = capture_stamp_pkg::DEF_FILT_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic en,
    output logic lvl
);
    localparam int HW = LEN - 1;

    logic [HW-1:0] hist;
    logic [LEN-1:0] window;
    logic           all_hi;
    logic           all_lo;
    logic           held;

    assign window = {hist, din};
    assign all_hi = &window;
    assign all_lo = ~|window;

    generate
        if (HW == 1) begin : g_h1
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= din;
            end
        end else begin : g_hn
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= {hist[HW-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
        end else if (all_hi) begin
            held <= 1'b1;
        end else if (all_lo) begin
            held <= 1'b0;
        end
    end

    assign lvl = en ? held : din;
endmodule

// File: rtl/capture_stamp_edge.sv
module capture_stamp_edge
    import capture_stamp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    input  edge_sel_e sel,
    input  logic      arm,
    output logic      evt
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign evt = arm & edge_hit(sel, lvl, prev);
endmodule

// File: rtl/capture_stamp.sv
module capture_stamp
    import capture_stamp_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int FILT_LEN    = DEF_FILT_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             filt_en,
    input  logic             edge_sel,
    input  logic             irq_en,
    input  logic             top_is_cap,
    input  logic             flag_clr,
    input  logic             cap_wr,
    input  logic [CNT_W-1:0] cap_wdata,
    output logic [CNT_W-1:0] cap_reg,
    output logic             cap_flag,
    output logic             cap_irq
);
    logic      pin_s;
    logic      pin_lvl;
    logic      cap_evt;
    edge_sel_e sel_e;
    cap_ctl_t  ctl;

    assign sel_e = edge_sel_e'(edge_sel);

    capture_stamp_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_pin),
        .dout (pin_s)
    );

    capture_stamp_filter #(.LEN(FILT_LEN)) filt_i (
        .clk (clk),
        .rst (rst),
        .din (pin_s),
        .en  (filt_en),
        .lvl (pin_lvl)
    );

    capture_stamp_edge edge_i (
        .clk (clk),
        .rst (rst),
        .lvl (pin_lvl),
        .sel (sel_e),
        .arm (~top_is_cap),
        .evt (cap_evt)
    );

    assign ctl = '{evt: cap_evt, wr: cap_wr, clr: flag_clr};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_reg <= '0;
        end else if (ctl.evt) begin
            cap_reg <= cnt_val;
        end else if (ctl.wr) begin
            cap_reg <= cap_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_flag <= 1'b0;
        end else if (ctl.evt) begin
            cap_flag <= 1'b1;
        end else if (ctl.clr) begin
            cap_flag <= 1'b0;
        end
    end

    assign cap_irq = cap_flag & irq_en;
endmodule

// File: rtl/capture_stamp_chk.sv
module capture_stamp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             top_is_cap,
    input logic             flag_clr,
    input logic             cap_wr,
    input logic             irq_en,
    input logic             cap_evt,
    input logic [CNT_W-1:0] cap_reg,
    input logic             cap_flag,
    input logic             cap_irq
);
    AST_TOP_NO_EVT: assert property (@(posedge clk) disable iff (rst)
        top_is_cap |-> !cap_evt); // R8

    AST_FLAG_RISE_NOT_TOP: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_flag) |-> !$past(top_is_cap)); // R8

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> cap_flag); // R6

    AST_FLAG_FALL_CLR: assert property (@(posedge clk) disable iff (rst)
        $fell(cap_flag) |-> $past(flag_clr)); // R9

    AST_REG_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_reg) |-> ($past(cap_wr) || $past(cap_evt))); // R11

    AST_IRQ_RISE_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_irq) |-> irq_en); // R7
endmodule

bind capture_stamp capture_stamp_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .top_is_cap (top_is_cap),
    .flag_clr   (flag_clr),
    .cap_wr     (cap_wr),
    .irq_en     (irq_en),
    .cap_evt    (cap_evt),
    .cap_reg    (cap_reg),
    .cap_flag   (cap_flag),
    .cap_irq    (cap_irq)
);

// File: tb/capture_stamp_tb_top.sv
module capture_stamp_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cap_pin = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         filt_en = 1'b0;
    logic         edge_sel = 1'b1;
    logic         irq_en = 1'b0;
    logic         top_is_cap = 1'b0;
    logic         flag_clr = 1'b0;
    logic         cap_wr = 1'b0;
    logic [W-1:0] cap_wdata = '0;
    logic [W-1:0] cap_reg;
    logic         cap_flag;
    logic         cap_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    capture_stamp dut_i (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .cnt_val(cnt_val),
        .filt_en(filt_en), .edge_sel(edge_sel), .irq_en(irq_en),
        .top_is_cap(top_is_cap), .flag_clr(flag_clr), .cap_wr(cap_wr),
        .cap_wdata(cap_wdata), .cap_reg(cap_reg), .cap_flag(cap_flag),
        .cap_irq(cap_irq)
    );

    // Reference model built from the requirements (2 sync edges, 4-sample agreement).
    logic         m_ph [0:5];
    logic         m_fcur, m_fprev;
    logic [W-1:0] m_cap;
    logic         m_flag;

    function automatic logic m_agree(logic a, logic b, logic c, logic d);
        return (a == b) && (b == c) && (c == d);
    endfunction

    always @(posedge clk) begin
        logic l, p, evt, fnew;
        if (rst) begin
            for (int i = 0; i < 6; i++) m_ph[i] = 1'b0;
            m_fcur = 1'b0; m_fprev = 1'b0; m_cap = '0; m_flag = 1'b0;
        end else begin
            l = filt_en ? m_fcur  : m_ph[1];
            p = filt_en ? m_fprev : m_ph[2];
            evt = !top_is_cap && (edge_sel ? (l && !p) : (!l && p));
            if (evt)         m_cap = cnt_val;
            else if (cap_wr) m_cap = cap_wdata;
            if (evt)           m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            fnew = m_agree(m_ph[1], m_ph[2], m_ph[3], m_ph[4]) ? m_ph[1] : m_fcur;
            m_fprev = m_fcur;
            m_fcur  = fnew;
            for (int i = 5; i > 0; i--) m_ph[i] = m_ph[i-1];
            m_ph[0] = cap_pin;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 cap_reg vs model", 32'(cap_reg), 32'(m_cap));
            chk("R9 cap_flag vs model", 32'(cap_flag), 32'(m_flag));
            chk("R7 cap_irq", 32'(cap_irq), 32'(m_flag & irq_en));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic measure(output int n);
        n = 0;
        for (int i = 1; i <= 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (cap_flag && n == 0) n = i;
        end
    endtask

    task automatic clear_flag();
        step(); flag_clr = 1'b1;
        step(); flag_clr = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        int run;
        logic [W-1:0] held;
        void'($urandom(32'h5A17));
        quiet(3);
        chk("R1 reset cap_reg", 32'(cap_reg), 0);
        chk("R1 reset cap_flag", 32'(cap_flag), 0);
        chk("R1 reset cap_irq", 32'(cap_irq), 0);
        rst = 1'b0;
        irq_en = 1'b1;
        quiet(8);

        // R2: unfiltered latency, rising edge
        cnt_val = 16'h0A0A;
        cap_pin = 1'b1;
        measure(lat);
        chk("R2 unfiltered latency", 32'(lat), 3);
        chk("R6 captured value", 32'(cap_reg), 32'h0A0A);
        chk("R7 irq with enable", 32'(cap_irq), 1);
        clear_flag();
        chk("R9 flag cleared", 32'(cap_flag), 0);

        // R5: falling edge with rising selected does nothing
        step(); cap_pin = 1'b0;
        quiet(8);
        chk("R5 falling ignored when rising selected", 32'(cap_flag), 0);

        // R4: filtered latency
        filt_en = 1'b1;
        quiet(2);
        step(); cnt_val = 16'h0B0B; cap_pin = 1'b1;
        measure(lat);
        chk("R4 filtered latency", 32'(lat), 7);
        clear_flag();

        // R5: falling edge select
        step(); edge_sel = 1'b0;
        quiet(3);
        chk("R10 edge_sel change no capture", 32'(cap_flag), 0);
        step(); cap_pin = 1'b0;
        quiet(10);
        chk("R5 falling edge captures", 32'(cap_flag), 1);
        clear_flag();
        step(); edge_sel = 1'b1;

        // R3: 3-sample pulse rejected, 4-sample pulse accepted
        step(); cap_pin = 1'b1;
        quiet(2);
        step(); cap_pin = 1'b0;
        quiet(12);
        chk("R3 short pulse rejected", 32'(cap_flag), 0);
        step(); cap_pin = 1'b1;
        quiet(3);
        step(); cap_pin = 1'b0;
        quiet(12);
        chk("R3 four-sample pulse accepted", 32'(cap_flag), 1);
        clear_flag();

        // R10: toggle edge select on a steady high level
        filt_en = 1'b0;
        step(); cap_pin = 1'b1;
        quiet(10);
        clear_flag();
        for (int i = 0; i < 6; i++) begin
            step(); edge_sel = ~edge_sel;
        end
        quiet(4);
        chk("R10 no capture from select toggles", 32'(cap_flag), 0);
        step(); edge_sel = 1'b1;

        // R9: capture and clear in the same cycle, flag already set
        step(); cap_pin = 1'b0;
        quiet(6);
        step(); cap_pin = 1'b1;
        measure(lat);
        chk("R9 flag set before collision", 32'(cap_flag), 1);
        step(); cap_pin = 1'b0;
        quiet(6);
        step(); cap_pin = 1'b1;
        step();
        step(); flag_clr = 1'b1; cnt_val = 16'hBEEF;
        @(negedge clk);
        chk("R9 set wins over clear", 32'(cap_flag), 1);
        chk("R6 collision capture value", 32'(cap_reg), 32'hBEEF);
        #1 flag_clr = 1'b0;
        clear_flag();

        // R8: capture disabled while register is the limit
        step(); top_is_cap = 1'b1;
        held = cap_reg;
        for (int i = 0; i < 12; i++) begin
            step(); cap_pin = ~cap_pin; cnt_val = 16'(i * 7 + 1);
        end
        quiet(6);
        chk("R8 no flag in limit mode", 32'(cap_flag), 0);
        chk("R8 cap_reg unchanged in limit mode", 32'(cap_reg), 32'(held));
        step(); cap_wr = 1'b1; cap_wdata = 16'h1357;
        step(); cap_wr = 1'b0;
        chk("R11 software load", 32'(cap_reg), 32'h1357);
        irq_en = 1'b0;
        step(); top_is_cap = 1'b0;
        quiet(10);

        // Random phase
        run = 0;
        for (int seg = 0; seg < 4; seg++) begin
            quiet(10);
            filt_en = seg[0];
            for (int i = 0; i < 2500; i++) begin
                step();
                if (run == 0) begin
                    cap_pin = ~cap_pin;
                    run = 1 + int'($urandom % 8);
                end
                run--;
                cnt_val   = 16'($urandom);
                cap_wdata = 16'($urandom);
                flag_clr  = ($urandom % 6) == 0;
                cap_wr    = ($urandom % 12) == 0;
                if (($urandom % 32) == 0) edge_sel = ~edge_sel;
                if (($urandom % 16) == 0) irq_en = ~irq_en;
                if (($urandom % 10) == 0) top_is_cap = ~top_is_cap;
            end
            flag_clr = 1'b0; cap_wr = 1'b0; top_is_cap = 1'b0;
        end
        quiet(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule